// File: doc/BRIEF.md
# Host Shadow Status Register

This block sits in a serial storage host adapter and keeps the host-visible copy of the attached device's status byte. A frame decoder hands it one decoded device-to-host frame at a time on a valid/ready stream: a type code, the Status byte, the ending status byte that a PIO Setup frame carries for use after its data phase, and the two 3-bit fields of a Set Device Bits frame. Each frame type updates its own subset of the status bits. A host write of the command register marks the device busy. The shadow value can be read at any time.

The block also sits on the outgoing path of host-to-device register frames. The attached device always acts as device 0, so a frame whose device byte selects device 1 is consumed and discarded, and a one-cycle flag is raised. Any other frame passes straight through. The inbound frame stream never stalls: `fis_ready` is tied high and a frame is taken in every cycle that `fis_valid` is high. On the outbound path, back-pressure from `tx_ready` reaches `h2d_ready` only for frames that are forwarded. A dropped frame is always accepted in its own cycle.

Top module: `shadow_status_reg`

## Requirements
- R1: After reset `status_o` reads 0x80 (busy bit 7 set, all other bits clear) until a frame or a host command changes it.
- R2: A frame with type code 0 (device-to-host register frame) replaces the whole shadow byte with `fis_status` from the following cycle. It also cancels any pending ending status.
- R3: A frame with type code 1 (PIO Setup) loads `fis_status` into the shadow at once and holds `fis_estatus` as pending. A `xfer_done` pulse then copies the pending value into the shadow and clears it. A `xfer_done` with nothing pending has no effect.
- R4: A frame with type code 2 (Set Device Bits) copies `fis_sdb_hi[2:0]` into status bits 6:4 and `fis_sdb_lo[2:0]` into status bits 2:0. Bit 7 (busy) and bit 3 (data request) keep their values.
- R5: A frame with type code 3 leaves the shadow unchanged. `fis_ready` is high at all times.
- R6: `cmd_wr` makes `status_o` bit 7 read 1 in the same cycle, and the shadow holds it from the next cycle. When `cmd_wr` and a frame arrive in the same cycle, bit 7 still ends at 1.
- R7: An outbound frame with `h2d_dev` bit 4 set is not forwarded. While it is offered, `tx_valid` is low, `h2d_ready` is high and `tx_drop` is high, so each drop pulses `tx_drop` for one cycle.
- R8: An outbound frame with `h2d_dev` bit 4 clear passes through with no register on the way. `tx_valid` follows `h2d_valid`, `h2d_ready` follows `tx_ready`, the device byte and body are unchanged, and `tx_drop` stays low.
- R9: When `xfer_done` releases a pending ending status in the same cycle that a frame arrives, the ending status is applied first and the frame's update is applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fis_valid | input | 1 | Decoded inbound frame present |
| fis_ready | output | 1 | Inbound frame accepted (always 1) |
| fis_type | input | 2 | 0 register, 1 PIO Setup, 2 Set Device Bits, 3 other |
| fis_status | input | 8 | Status byte of the frame |
| fis_estatus | input | 8 | Ending status of a PIO Setup frame |
| fis_sdb_hi | input | FIELD_W | Set Device Bits high status field |
| fis_sdb_lo | input | FIELD_W | Set Device Bits low status field |
| xfer_done | input | 1 | Pulse when the PIO data phase ends |
| cmd_wr | input | 1 | Host write of the command register |
| status_o | output | 8 | Shadow status byte |
| h2d_valid | input | 1 | Outbound register frame offered |
| h2d_ready | output | 1 | Outbound frame consumed |
| h2d_dev | input | DEV_W | Device byte of the outbound frame |
| h2d_body | input | BODY_W | Remaining outbound frame contents |
| tx_valid | output | 1 | Forwarded frame valid |
| tx_ready | input | 1 | Link can take the forwarded frame |
| tx_dev | output | DEV_W | Forwarded device byte |
| tx_body | output | BODY_W | Forwarded contents |
| tx_drop | output | 1 | Frame for device 1 discarded this cycle |

## Verification
The bench targets the bits that a Set Device Bits frame must not touch. A design that merged the whole byte would lose busy or data request. It also covers a second `xfer_done` after the pending value has been used: if the pending flag were not cleared, the old ending status would be reloaded. A register frame that arrives between a PIO Setup frame and the end of its data phase is also exercised. A design that kept the pending value would overwrite the newer status. The same-cycle cases, `cmd_wr` with a frame and `xfer_done` with a Set Device Bits frame, catch a wrong update order. The outbound gate is checked with `tx_ready` low, which shows whether a device-1 frame stalls instead of being dropped.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int STAT_W   = 8;
  localparam int BSY_BIT  = 7;
  localparam int DRDY_BIT = 6;
  localparam int DRQ_BIT  = 3;
  localparam int DEV_BIT  = 4;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h80;

  typedef enum logic [1:0] {
    FT_REG_D2H   = 2'd0,
    FT_PIO_SETUP = 2'd1,
    FT_DEV_BITS  = 2'd2,
    FT_OTHER     = 2'd3
  } frame_t;
endpackage

// File: rtl/ssr_next.sv
module ssr_next
  import ssr_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic [STAT_W-1:0]  cur,
  input  logic               pend_vld,
  input  logic [STAT_W-1:0]  pend_val,
  input  logic               fis_valid,
  input  logic [1:0]         fis_type,
  input  logic [STAT_W-1:0]  fis_status,
  input  logic [STAT_W-1:0]  fis_estatus,
  input  logic [FIELD_W-1:0] fis_sdb_hi,
  input  logic [FIELD_W-1:0] fis_sdb_lo,
  input  logic               xfer_done,
  input  logic               cmd_wr,
  output logic [STAT_W-1:0]  nxt,
  output logic               nxt_pend_vld,
  output logic [STAT_W-1:0]  nxt_pend_val
);
  localparam int HI_LSB = DRDY_BIT - FIELD_W + 1;
  localparam int LO_LSB = 0;

  logic [STAT_W-1:0] base;

  always_comb begin
    base         = cur;
    nxt_pend_vld = pend_vld;
    nxt_pend_val = pend_val;
    // ending status of a finished data phase lands first (R9)
    if (xfer_done && pend_vld) begin
      base         = pend_val;
      nxt_pend_vld = 1'b0;
    end
    nxt = base;
    if (fis_valid) begin
      case (frame_t'(fis_type))
        FT_REG_D2H: begin
          nxt          = fis_status;
          nxt_pend_vld = 1'b0;
        end
        FT_PIO_SETUP: begin
          nxt          = fis_status;
          nxt_pend_vld = 1'b1;
          nxt_pend_val = fis_estatus;
        end
        FT_DEV_BITS: begin
          for (int i = 0; i < FIELD_W; i++) begin
            nxt[HI_LSB+i] = fis_sdb_hi[i];
            nxt[LO_LSB+i] = fis_sdb_lo[i];
          end
        end
        default: ;
      endcase
    end
    if (cmd_wr) nxt[BSY_BIT] = 1'b1;
  end
endmodule

// File: rtl/ssr_dev_gate.sv
module ssr_dev_gate
  import ssr_pkg::*;
#(
  parameter int DEV_W  = 8,
  parameter int BODY_W = 24
) (
  input  logic              h2d_valid,
  output logic              h2d_ready,
  input  logic [DEV_W-1:0]  h2d_dev,
  input  logic [BODY_W-1:0] h2d_body,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DEV_W-1:0]  tx_dev,
  output logic [BODY_W-1:0] tx_body,
  output logic              tx_drop
);
  logic other_dev;

  assign other_dev = h2d_dev[DEV_BIT];
  assign tx_valid  = h2d_valid & ~other_dev;
  assign h2d_ready = other_dev | tx_ready;
  assign tx_drop   = h2d_valid & other_dev;
  assign tx_dev    = h2d_dev;
  assign tx_body   = h2d_body;
endmodule

// File: rtl/shadow_status_reg.sv
module shadow_status_reg
  import ssr_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int DEV_W   = 8,
  parameter int BODY_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fis_valid,
  output logic               fis_ready,
  input  logic [1:0]         fis_type,
  input  logic [7:0]         fis_status,
  input  logic [7:0]         fis_estatus,
  input  logic [FIELD_W-1:0] fis_sdb_hi,
  input  logic [FIELD_W-1:0] fis_sdb_lo,
  input  logic               xfer_done,
  input  logic               cmd_wr,
  output logic [7:0]         status_o,
  input  logic               h2d_valid,
  output logic               h2d_ready,
  input  logic [DEV_W-1:0]   h2d_dev,
  input  logic [BODY_W-1:0]  h2d_body,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [DEV_W-1:0]   tx_dev,
  output logic [BODY_W-1:0]  tx_body,
  output logic               tx_drop
);
  logic [STAT_W-1:0] shadow_q, pend_q, shadow_d, pend_d;
  logic              pend_vld_q, pend_vld_d;
  logic [STAT_W-1:0] bsy_mask;

  assign fis_ready = 1'b1;

  ssr_next #(.FIELD_W(FIELD_W)) u_next (
    .cur(shadow_q), .pend_vld(pend_vld_q), .pend_val(pend_q),
    .fis_valid(fis_valid), .fis_type(fis_type), .fis_status(fis_status),
    .fis_estatus(fis_estatus), .fis_sdb_hi(fis_sdb_hi), .fis_sdb_lo(fis_sdb_lo),
    .xfer_done(xfer_done), .cmd_wr(cmd_wr),
    .nxt(shadow_d), .nxt_pend_vld(pend_vld_d), .nxt_pend_val(pend_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= STAT_RST;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      shadow_q   <= shadow_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  // host command write shows busy without waiting for the edge
  always_comb begin
    bsy_mask          = '0;
    bsy_mask[BSY_BIT] = cmd_wr;
  end
  assign status_o = shadow_q | bsy_mask;

  ssr_dev_gate #(.DEV_W(DEV_W), .BODY_W(BODY_W)) u_gate (
    .h2d_valid(h2d_valid), .h2d_ready(h2d_ready), .h2d_dev(h2d_dev),
    .h2d_body(h2d_body), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_dev(tx_dev), .tx_body(tx_body), .tx_drop(tx_drop)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fis_valid,
  input logic [1:0]       fis_type,
  input logic [7:0]       fis_status,
  input logic             xfer_done,
  input logic             cmd_wr,
  input logic [7:0]       status_o,
  input logic [7:0]       shadow_q,
  input logic             h2d_valid,
  input logic             h2d_ready,
  input logic [DEV_W-1:0] h2d_dev,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_drop
);
  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> shadow_q == STAT_RST);

  assert_reg_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && fis_type == FT_REG_D2H && !cmd_wr |=> shadow_q == $past(fis_status));

  assert_sdb_keeps_bsy_drq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && fis_type == FT_DEV_BITS && !cmd_wr && !xfer_done |=>
      shadow_q[BSY_BIT] == $past(shadow_q[BSY_BIT]) &&
      shadow_q[DRQ_BIT] == $past(shadow_q[DRQ_BIT]));

  assert_cmd_busy_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> status_o[BSY_BIT]);

  assert_cmd_busy_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> shadow_q[BSY_BIT]);

  assert_drop_dev1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h2d_valid && h2d_dev[DEV_BIT] |-> !tx_valid && h2d_ready && tx_drop);

  assert_pass_dev0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    h2d_valid && !h2d_dev[DEV_BIT] |-> tx_valid && h2d_ready == tx_ready && !tx_drop);
endmodule

bind shadow_status_reg ssr_checker #(.DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fis_valid(fis_valid), .fis_type(fis_type),
  .fis_status(fis_status), .xfer_done(xfer_done), .cmd_wr(cmd_wr),
  .status_o(status_o), .shadow_q(shadow_q), .h2d_valid(h2d_valid),
  .h2d_ready(h2d_ready), .h2d_dev(h2d_dev), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_drop(tx_drop)
);

// File: tb/shadow_status_reg_tb.sv
module shadow_status_reg_tb;
  localparam int FIELD_W = 3;
  localparam int DEV_W   = 8;
  localparam int BODY_W  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fis_valid = 0, fis_ready, xfer_done = 0, cmd_wr = 0;
  logic [1:0] fis_type = 0;
  logic [7:0] fis_status = 0, fis_estatus = 0, status_o;
  logic [FIELD_W-1:0] fis_sdb_hi = 0, fis_sdb_lo = 0;
  logic h2d_valid = 0, h2d_ready, tx_valid, tx_ready = 0, tx_drop;
  logic [DEV_W-1:0] h2d_dev = 0, tx_dev;
  logic [BODY_W-1:0] h2d_body = 0, tx_body;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shadow_status_reg #(.FIELD_W(FIELD_W), .DEV_W(DEV_W), .BODY_W(BODY_W)) u_dut (.*);

  typedef struct packed {
    logic       fv;
    logic [1:0] ft;
    logic [7:0] st;
    logic [7:0] est;
    logic [2:0] hi;
    logic [2:0] lo;
    logic       xd;
    logic       cw;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 8'h50, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 8'h50, 4'd2}, // R2
    '{1'b1, 2'd2, 8'h00, 8'h00, 3'b101, 3'b011, 1'b0, 1'b0, 8'h53, 4'd4}, // R4
    '{1'b0, 2'd0, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0, 1'b1, 8'hD3, 4'd6}, // R6
    '{1'b1, 2'd2, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 8'h80, 4'd4}, // R4 busy kept
    '{1'b1, 2'd0, 8'h58, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 8'h58, 4'd2}, // R2
    '{1'b1, 2'd2, 8'h00, 8'h00, 3'b111, 3'b111, 1'b0, 1'b0, 8'h7F, 4'd4}, // R4 drq kept
    '{1'b1, 2'd1, 8'h58, 8'h50, 3'b000, 3'b000, 1'b0, 1'b0, 8'h58, 4'd3}, // R3 load
    '{1'b0, 2'd0, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, 8'h50, 4'd3}, // R3 ending
    '{1'b0, 2'd0, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, 8'h50, 4'd3}, // R3 no pending
    '{1'b1, 2'd3, 8'hFF, 8'hFF, 3'b111, 3'b111, 1'b0, 1'b0, 8'h50, 4'd5}, // R5
    '{1'b1, 2'd1, 8'h88, 8'h41, 3'b000, 3'b000, 1'b0, 1'b0, 8'h88, 4'd3}, // R3
    '{1'b1, 2'd0, 8'h51, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 8'h51, 4'd2}, // R2 cancels
    '{1'b0, 2'd0, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, 8'h51, 4'd2}, // R2 pending gone
    '{1'b1, 2'd1, 8'h08, 8'h50, 3'b000, 3'b000, 1'b0, 1'b0, 8'h08, 4'd3}, // R3
    '{1'b1, 2'd2, 8'h00, 8'h00, 3'b010, 3'b001, 1'b1, 1'b0, 8'h21, 4'd9}, // R9
    '{1'b1, 2'd0, 8'h50, 8'h00, 3'b000, 3'b000, 1'b0, 1'b1, 8'hD0, 4'd6}, // R6
    '{1'b1, 2'd2, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0, 1'b1, 8'h80, 4'd6}  // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fis_valid = 0; xfer_done = 0; cmd_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value
    check("R1 during reset", status_o, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", status_o, 8'h80);
    check("R5 fis_ready", fis_ready, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fis_valid = VECS[i].fv; fis_type = VECS[i].ft; fis_status = VECS[i].st;
      fis_estatus = VECS[i].est; fis_sdb_hi = VECS[i].hi; fis_sdb_lo = VECS[i].lo;
      xfer_done = VECS[i].xd; cmd_wr = VECS[i].cw;
      @(posedge clk); #1;
      idle_inputs();
      #0;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), status_o, VECS[i].exp);
    end

    // R6: busy visible in the same cycle as the command write
    @(negedge clk);
    fis_valid = 1; fis_type = 2'd0; fis_status = 8'h40;
    @(posedge clk); #1; idle_inputs();
    @(negedge clk);
    cmd_wr = 1; #1;
    check("R6 same-cycle busy", status_o, 8'hC0);
    @(posedge clk); #1; idle_inputs(); #0;
    check("R6 held busy", status_o, 8'hC0);

    // R7: device 1 frame dropped even with link stalled
    @(negedge clk);
    h2d_valid = 1; h2d_dev = 8'h10; h2d_body = 24'hABCDEF; tx_ready = 0; #1;
    check("R7 tx_valid", tx_valid, 1'b0);
    check("R7 h2d_ready", h2d_ready, 1'b1);
    check("R7 tx_drop", tx_drop, 1'b1);
    // R8: device 0 frame passes, back-pressure follows link
    h2d_dev = 8'hE0; #1;
    check("R8 tx_valid", tx_valid, 1'b1);
    check("R8 stalled ready", h2d_ready, 1'b0);
    check("R8 tx_drop", tx_drop, 1'b0);
    check("R8 tx_dev", tx_dev, 8'hE0);
    check("R8 tx_body", tx_body, 24'hABCDEF);
    tx_ready = 1; #1;
    check("R8 ready follows", h2d_ready, 1'b1);
    h2d_valid = 0; #1;
    check("R7 no drop when idle", tx_drop, 1'b0);
    check("R8 no valid when idle", tx_valid, 1'b0);

    // R1: reset in mid-run returns to busy
    @(negedge clk);
    rst_n = 0; #1;
    check("R1 mid-run reset", status_o, 8'h80);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after second reset", status_o, 8'h80);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule